// File: doc/BRIEF.md
# Toggle-Handshake Record Readout Buffer

This block sits between a bus-capture unit and a slow external reader. Each captured record, a fixed-width word, goes into an internal FIFO through a valid/ready write port. The reader pulls records out one at a time over two single-bit lines that work by toggling. To ask for the next record, the reader inverts its request line. The block then puts that record on a parallel output bus and inverts its acknowledge line in reply.

The reader knows the output bus holds a settled record whenever its own request level equals the acknowledge level. A separate availability flag tells it whether any unread record is waiting. If the reader asks while the buffer is empty, the block drives an all-zero record and still sends the acknowledge, so the handshake never stalls.

The request line comes from outside the clock domain. It passes through a configurable synchronizer chain, and a request is any change of its synchronized level.

Top module: `rec_toggle_readout`

## Requirements
- R1: After reset, rd_avail is 0, rd_data is all zero, rd_ready is 0 and cap_ready is 1, so an idle reader holding rd_next low sees rd_ready equal to rd_next.
- R2: cap_ready is 1 exactly when fewer than DEPTH records (default 16) are stored. A push with cap_valid high while cap_ready is 0 is discarded and leaves the stored contents unchanged.
- R3: Records reach rd_data in the order in which they were accepted.
- R4: A rising edge and a falling edge of rd_next each count as one request. A level held steady makes no request.
- R5: With the default two-stage synchronizer, a change of rd_next that settles before clock edge k loads rd_data at edge k+2. rd_ready inverts at edge k+3.
- R6: A request made while the buffer is empty loads all-zero data onto rd_data, still inverts rd_ready, and does not alter the buffer.
- R7: rd_avail is 1 exactly when at least one unread record is stored. It falls at the same clock edge at which the last record is loaded onto rd_data.
- R8: Once rd_ready has answered, rd_ready equals rd_next, and rd_data holds its value until the next request.
- R9: A push and a pop at the same edge are both carried out, and the stored count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | Capture unit offers a record |
| cap_data | input | REC_W | Record offered by the capture unit |
| cap_ready | output | 1 | Buffer can accept a record |
| rd_next | input | 1 | Reader request line, asynchronous, toggled to request |
| rd_ready | output | 1 | Acknowledge line, toggled once data is loaded |
| rd_avail | output | 1 | At least one unread record is stored |
| rd_data | output | REC_W | Presented record |

## Verification
The bench builds the block with REC_W at 47 and DEPTH at 6. The shallow, non-power-of-two depth selects the explicit pointer-wrap variant. It also means the full condition, pushes dropped while full, and pointer wrap-around are all reached within a few dozen cycles. SYNC_STAGES stays at 2, so the bench's request latency model matches the timing stated in R5. A queue-based model follows every edge, so the same run also covers reads of an empty buffer, simultaneous push and pop, and requests issued back to back.

// File: rtl/trd_pkg.sv
package trd_pkg;

   // Acknowledge sequencing: a load is followed one cycle later by the toggle.
   typedef enum logic {
      ACK_IDLE = 1'b0,
      ACK_DUE  = 1'b1
   } ack_state_e;

   // Pointer width for a ring of d entries (at least one bit).
   function automatic int unsigned ring_ptr_bits(input int unsigned d);
      return (d <= 2) ? 1 : $clog2(d);
   endfunction

   // True when d is a power of two, so pointers may wrap naturally.
   function automatic bit is_pow2(input int unsigned d);
      return (d != 0) && ((d & (d - 1)) == 0);
   endfunction

endpackage

// File: rtl/trd_req_detect.sv
module trd_req_detect #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_lvl,
   output logic req_o
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("trd_req_detect: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              dly_q;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= async_lvl;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[k] <= 1'b0;
            else        chain_q[k] <= chain_q[k-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly_q <= 1'b0;
      else        dly_q <= chain_q[LAST];
   end

   // Any level change of the synchronized line is one request.
   assign req_o = chain_q[LAST] ^ dly_q;

endmodule

// File: rtl/trd_fifo.sv
module trd_fifo
   import trd_pkg::*;
#(
   parameter int unsigned W     = 47,
   parameter int unsigned DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_req,
   input  logic [W-1:0] push_data,
   input  logic         pop_req,
   output logic [W-1:0] head_data,
   output logic         empty_o,
   output logic         full_o
);
   localparam int unsigned PTR_W = ring_ptr_bits(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam bit          POW2  = is_pow2(DEPTH);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("trd_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("trd_fifo: W must be at least 1");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_nxt, rd_ptr_nxt;
   logic [CNT_W-1:0] count_q;
   logic             do_push, do_pop;

   assign empty_o = (count_q == '0);
   assign full_o  = (count_q == CNT_MAX);
   assign do_push = push_req && !full_o;
   assign do_pop  = pop_req  && !empty_o;
   assign head_data = mem[rd_ptr_q];

   if (POW2) begin : g_wrap_natural
      assign wr_ptr_nxt = wr_ptr_q + 1'b1;
      assign rd_ptr_nxt = rd_ptr_q + 1'b1;
   end else begin : g_wrap_compare
      assign wr_ptr_nxt = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      assign rd_ptr_nxt = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr_q] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (do_push) wr_ptr_q <= wr_ptr_nxt;
         if (do_pop)  rd_ptr_q <= rd_ptr_nxt;
         unique case ({do_push, do_pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && full_o && !pop_req) |=> (count_q == $past(count_q))); // R2
   AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_o && !push_req) |=> empty_o); // R6
   AST_SAME_EDGE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && pop_req && !full_o && !empty_o) |=> (count_q == $past(count_q))); // R9

endmodule

// File: rtl/trd_out_stage.sv
module trd_out_stage
   import trd_pkg::*;
#(
   parameter int unsigned W = 47
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_i,
   input  logic         fifo_empty_i,
   input  logic [W-1:0] head_i,
   output logic         pop_o,
   output logic [W-1:0] data_o,
   output logic         ack_o
);
   ack_state_e   st_q;
   logic [W-1:0] data_q;
   logic         ack_q;

   assign pop_o = req_i && !fifo_empty_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         ack_q  <= 1'b0;
         st_q   <= ACK_IDLE;
      end else begin
         if (req_i) data_q <= fifo_empty_i ? '0 : head_i;
         if (st_q == ACK_DUE) ack_q <= ~ack_q;
         st_q <= req_i ? ACK_DUE : ACK_IDLE;
      end
   end

   assign data_o = data_q;
   assign ack_o  = ack_q;

   AST_ACK_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_q != $past(ack_q)) |-> $past(req_i, 2)); // R5
   AST_ZERO_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && fifo_empty_i) |=> (data_q == '0)); // R6
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> $stable(data_q)); // R8

endmodule

// File: rtl/rec_toggle_readout.sv
module rec_toggle_readout #(
   parameter int unsigned REC_W       = 47,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_valid,
   input  logic [REC_W-1:0] cap_data,
   output logic             cap_ready,
   input  logic             rd_next,
   output logic             rd_ready,
   output logic             rd_avail,
   output logic [REC_W-1:0] rd_data
);
   logic             req;
   logic             pop;
   logic             fifo_empty;
   logic             fifo_full;
   logic [REC_W-1:0] head;

   trd_req_detect #(.STAGES(SYNC_STAGES)) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .async_lvl (rd_next),
      .req_o     (req)
   );

   trd_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_req  (cap_valid),
      .push_data (cap_data),
      .pop_req   (pop),
      .head_data (head),
      .empty_o   (fifo_empty),
      .full_o    (fifo_full)
   );

   trd_out_stage #(.W(REC_W)) u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req),
      .fifo_empty_i (fifo_empty),
      .head_i       (head),
      .pop_o        (pop),
      .data_o       (rd_data),
      .ack_o        (rd_ready)
   );

   assign cap_ready = !fifo_full;
   assign rd_avail  = !fifo_empty;

   AST_AVAIL_FALL_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_avail) |-> $past(pop)); // R7
   AST_AVAIL_RISE_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_avail) |-> $past(cap_valid)); // R7

endmodule

// File: tb/rec_toggle_readout_tb.sv
module rec_toggle_readout_tb;
   localparam int unsigned W = 47;
   localparam int unsigned D = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cap_valid = 1'b0;
   logic [W-1:0] cap_data = '0;
   logic         cap_ready;
   logic         rd_next = 1'b0;
   logic         rd_ready;
   logic         rd_avail;
   logic [W-1:0] rd_data;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   rec_toggle_readout #(.REC_W(W), .DEPTH(D), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_data(cap_data),
      .cap_ready(cap_ready), .rd_next(rd_next), .rd_ready(rd_ready),
      .rd_avail(rd_avail), .rd_data(rd_data)
   );

   // Reference model state
   logic [W-1:0] q[$];
   logic [W-1:0] m_data = '0;
   logic         m_ack = 1'b0;
   logic         m_pend = 1'b0;
   logic         h_a = 1'b0, h_b = 1'b0, h_c = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
      end
   endtask

   // One clock: update the model with the inputs present at the edge, then compare.
   task automatic tick();
      bit req;
      int sz0;
      @(posedge clk);
      req = (h_b != h_c);
      h_c = h_b; h_b = h_a; h_a = rd_next;
      sz0 = q.size();
      if (m_pend) m_ack = ~m_ack;
      m_pend = req;
      if (req) begin
         if (sz0 > 0) m_data = q.pop_front();
         else         m_data = '0;
      end
      if (cap_valid && sz0 < int'(D)) q.push_back(cap_data);
      #1;
      chk(rd_data == m_data, "R3/R6 rd_data", 64'(rd_data), 64'(m_data));
      chk(rd_ready == m_ack, "R5 rd_ready", 64'(rd_ready), 64'(m_ack));
      chk(rd_avail == (q.size() != 0), "R7 rd_avail", 64'(rd_avail), 64'(q.size() != 0));
      chk(cap_ready == (q.size() < int'(D)), "R2 cap_ready", 64'(cap_ready), 64'(q.size() < int'(D)));
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic push_n(input int n, input logic [W-1:0] base);
      for (int i = 0; i < n; i++) begin
         cap_valid = 1'b1;
         cap_data  = base ^ W'(i * 32'h9E37_79B1);
         tick();
      end
      cap_valid = 1'b0;
   endtask

   task automatic read_one(output logic [W-1:0] got);
      rd_next = ~rd_next;
      ticks(5);
      chk(rd_ready == rd_next, "R8 ready equals next", 64'(rd_ready), 64'(rd_next));
      got = rd_data;
   endtask

   initial begin
      logic [W-1:0] got;
      logic [W-1:0] exp0;
      #9;
      chk(rd_avail == 1'b0 && rd_ready == 1'b0, "R1 reset flags", 64'({rd_avail, rd_ready}), 64'(0));
      chk(rd_data == '0 && cap_ready == 1'b1, "R1 reset data/ready", 64'(rd_data), 64'(0));
      rst_n = 1'b1;
      ticks(3);

      // R6: read while empty
      read_one(got);
      chk(got == '0, "R6 empty read zero", 64'(got), 64'(0));

      // R4: steady level makes no request
      ticks(6);
      chk(rd_ready == rd_next, "R4 no request on steady level", 64'(rd_ready), 64'(rd_next));

      // R3/R4: three records, read with falling then rising toggles
      exp0 = 47'h1234_5678_9AB;
      push_n(3, exp0);
      read_one(got);
      chk(got == exp0, "R3 first record (falling toggle R4)", 64'(got), 64'(exp0));
      read_one(got);
      chk(got == (exp0 ^ W'(32'h9E37_79B1)), "R4 second record on rising toggle", 64'(got), 64'(exp0 ^ W'(32'h9E37_79B1)));
      read_one(got);
      chk(rd_avail == 1'b0, "R7 avail low after last", 64'(rd_avail), 64'(0));

      // R5 latency: change before edge k, data at k+2, ack at k+3
      push_n(1, 47'h0AB_CDEF_0123);
      rd_next = ~rd_next;
      tick(); tick();
      chk(rd_data != 47'h0AB_CDEF_0123, "R5 data not early", 64'(rd_data), 64'(0));
      tick();
      chk(rd_data == 47'h0AB_CDEF_0123, "R5 data at k+2", 64'(rd_data), 64'(47'h0AB_CDEF_0123));
      chk(rd_ready != rd_next, "R5 ack not yet", 64'(rd_ready), 64'(~rd_next));
      tick();
      chk(rd_ready == rd_next, "R5 ack at k+3", 64'(rd_ready), 64'(rd_next));
      ticks(2);

      // R2: fill past capacity, extras dropped
      push_n(D + 3, 47'h7000_0000_0055);
      chk(cap_ready == 1'b0, "R2 full blocks", 64'(cap_ready), 64'(0));
      for (int i = 0; i < int'(D); i++) begin
         read_one(got);
         chk(got == (47'h7000_0000_0055 ^ W'(i * 32'h9E37_79B1)), "R2 order after overflow attempt",
             64'(got), 64'(47'h7000_0000_0055 ^ W'(i * 32'h9E37_79B1)));
      end
      read_one(got);
      chk(got == '0, "R2 dropped pushes not stored", 64'(got), 64'(0));

      // R9: simultaneous push and pop with back-to-back toggles
      push_n(2, 47'h0F0F_0F0F_0F0F);
      cap_valid = 1'b1;
      for (int i = 0; i < 8; i++) begin
         cap_data = W'(i + 100);
         if (i % 2 == 0) rd_next = ~rd_next;
         tick();
      end
      cap_valid = 1'b0;
      ticks(8);
      chk(rd_ready == rd_next, "R9 handshake settles", 64'(rd_ready), 64'(rd_next));
      while (q.size() > 0) read_one(got);
      chk(rd_avail == 1'b0, "R9 drained", 64'(rd_avail), 64'(0));

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule